// File: doc/BRIEF.md
# Interrupt Core and Pin Router

This block distributes interrupts across a cluster of cores. It takes a vector of already-masked pending shared interrupts and, for each one, uses a per-interrupt core-select register and a per-interrupt pin-map register to decide which cores see it and on which interrupt output pin. Each core also has seven local interrupt sources. Each local source has its own pending input, its own mask bit and its own pin-map register. The router ORs all these requests into one vector of pin requests per core and registers it.

Configuration uses a single write port. A write carries the requesting core, an operation code, an index and a data word. Local-register writes normally target the requesting core's own bank. With the redirect flag set, they target the core named in that core's redirect register. A read-only configuration output reports the number of cores minus one.

Top module: `irq_core_pin_router`

## Requirements
- R1: After reset, all pin-map and core-select registers are cleared, every local mask bit is clear and `core_pins` is zero. Pins stay zero whatever the pending inputs are until the router is programmed.
- R2: `cfg_cores_m1` always reads N_CORES-1.
- R3: The write operation codes are 0 (shared pin-map), 1 (shared core-select), 2 (local pin-map), 3 (local mask set), 4 (local mask clear) and 5 (redirect). A pin-map write stores the valid flag from `wr_data[DW-1]` and the pin number from `wr_data[PW-1:0]`. A pending shared interrupt with a valid map to pin p, and with bit v of its core-select set, raises `core_pins[v*N_PINS+p]`.
- R4: A shared or local source whose map valid flag is clear, or whose pin number is N_PINS or above, drives no pin.
- R5: The core-select register is written from `wr_data[N_CORES-1:0]`, and bit v selects core v. Several set bits route the interrupt to each selected core. An all-zero value routes it nowhere.
- R6: Each core has seven local sources: 0 watchdog, 1 compare, 2 timer, 3 performance counter, 4 software 0, 5 software 1 and 6 debug channel. The pending bit for source s of core c is `loc_pend[c*7+s]`. The source's pin-map register is selected by `wr_idx[2:0]`, and index 7 selects none.
- R7: A local source drives its pin only while its mask bit is set. Operation 3 sets the mask bits where `wr_data[6:0]` is 1. Operation 4 clears those bits. Zero data bits leave their mask bits unchanged.
- R8: Operation 5 stores `wr_data[CW-1:0]` as the redirect register of `wr_core`. Local operations with `wr_other`=1 act on the core held in the redirect register of `wr_core`, and leave the requesting core's own bank unchanged. Operation codes 6 and 7 change nothing.
- R9: Each pin is the OR of every shared and local request routed to it.
- R10: `core_pins` is registered. A register write at clock edge T shows at the pins after edge T+1. A change on a pending input before edge T shows at the pins after edge T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sh_pend | input | N_SHARED | Masked pending shared interrupts |
| loc_pend | input | N_CORES*7 | Pending local sources, core-major |
| wr_en | input | 1 | Register write strobe |
| wr_core | input | CW | Core issuing the write |
| wr_other | input | 1 | Redirect local operations through the redirect register |
| wr_op | input | 3 | Operation code |
| wr_idx | input | IW | Shared interrupt or local source index |
| wr_data | input | DW | Write data |
| core_pins | output | N_CORES*N_PINS | Pin requests, core-major |
| cfg_cores_m1 | output | CW | Number of cores minus one |

## Verification
The hardest case to reach is a redirected local write. The write has to land in another core's bank while the requester's own bank stays untouched. The bench first programs the redirect register, then issues a pin-map write and a mask write with the redirect flag set. It then asserts the watchdog pending bit on both the requester and the target core, so that any write that went to the wrong bank would show up as an extra pin. A second hard case is separating write latency from input latency. The bench checks the pins right after the final map write, when they must still read zero, and again one edge later.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned LOCAL_SRCS = 7;
  localparam int unsigned LIDX_W     = 3;

  typedef enum logic [2:0] {
    OP_SH_PIN  = 3'd0,
    OP_SH_CORE = 3'd1,
    OP_LC_PIN  = 3'd2,
    OP_LC_SET  = 3'd3,
    OP_LC_CLR  = 3'd4,
    OP_OTHER   = 3'd5
  } wr_op_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/irq_other_sel.sv
module irq_other_sel #(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned CW      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_op,
  input  logic [CW-1:0] wr_core,
  input  logic          wr_other,
  input  logic [CW-1:0] other_fld,
  output logic [CW-1:0] wr_target
);
  import irq_router_pkg::*;

  logic [CW-1:0] other_q [N_CORES];
  logic [CW-1:0] redirect_core;

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    localparam logic [CW-1:0] CID = CW'(c);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) other_q[c] <= '0;
      else if (wr_en && wr_op == OP_OTHER && wr_core == CID) other_q[c] <= other_fld;
    end
  end

  always_comb begin
    redirect_core = '0;
    for (int c = 0; c < N_CORES; c++)
      if (wr_core == CW'(c)) redirect_core = other_q[c];
  end

  assign wr_target = wr_other ? redirect_core : wr_core;
endmodule

// File: rtl/irq_shared_map.sv
module irq_shared_map #(
  parameter int unsigned N_SHARED = 16,
  parameter int unsigned N_CORES  = 4,
  parameter int unsigned N_PINS   = 6,
  parameter int unsigned IW       = 4,
  parameter int unsigned PW       = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [2:0]                  wr_op,
  input  logic [IW-1:0]               wr_idx,
  input  logic                        vld_fld,
  input  logic [PW-1:0]               pin_fld,
  input  logic [N_CORES-1:0]          core_fld,
  input  logic [N_SHARED-1:0]         sh_pend,
  output logic [N_CORES*N_PINS-1:0]   sh_req
);
  import irq_router_pkg::*;

  logic               vld_q  [N_SHARED];
  logic [PW-1:0]      pin_q  [N_SHARED];
  logic [N_CORES-1:0] core_q [N_SHARED];

  function automatic logic steers(input logic pend, input logic vld, input logic [PW-1:0] pin,
                                  input int unsigned p);
    return pend && vld && (pin == PW'(p));
  endfunction

  for (genvar i = 0; i < N_SHARED; i++) begin : g_intr
    localparam logic [IW-1:0] IID = IW'(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[i]  <= 1'b0;
        pin_q[i]  <= '0;
        core_q[i] <= '0;
      end else if (wr_en && wr_idx == IID) begin
        if (wr_op == OP_SH_PIN) begin
          vld_q[i] <= vld_fld;
          pin_q[i] <= pin_fld;
        end
        if (wr_op == OP_SH_CORE) core_q[i] <= core_fld;
      end
    end
  end

  always_comb begin
    sh_req = '0;
    for (int v = 0; v < N_CORES; v++)
      for (int p = 0; p < N_PINS; p++)
        for (int i = 0; i < N_SHARED; i++)
          if (core_q[i][v] && steers(sh_pend[i], vld_q[i], pin_q[i], p))
            sh_req[v*N_PINS+p] = 1'b1;
  end
endmodule

// File: rtl/irq_local_bank.sv
module irq_local_bank #(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned N_PINS  = 6,
  parameter int unsigned PW      = 3,
  parameter int unsigned CW      = 2
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     wr_en,
  input  logic [2:0]                               wr_op,
  input  logic [irq_router_pkg::LIDX_W-1:0]        wr_src,
  input  logic [CW-1:0]                            wr_target,
  input  logic                                     vld_fld,
  input  logic [PW-1:0]                            pin_fld,
  input  logic [irq_router_pkg::LOCAL_SRCS-1:0]    mask_fld,
  input  logic [N_CORES*irq_router_pkg::LOCAL_SRCS-1:0] loc_pend,
  output logic [N_CORES*N_PINS-1:0]                loc_req,
  output logic [N_CORES*irq_router_pkg::LOCAL_SRCS-1:0] loc_mask
);
  import irq_router_pkg::*;
  localparam int unsigned LS = LOCAL_SRCS;

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    localparam logic [CW-1:0] CID = CW'(c);
    logic [LS-1:0]     mask_q;
    logic [LS-1:0]     vld_q;
    logic [PW-1:0]     pin_q [LS];
    logic              hit;
    logic [N_PINS-1:0] req;
    logic [LS-1:0]     live;

    assign hit = wr_en && (wr_target == CID);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q <= '0;
        vld_q  <= '0;
        for (int s = 0; s < LS; s++) pin_q[s] <= '0;
      end else if (hit) begin
        if (wr_op == OP_LC_SET) mask_q <= mask_q | mask_fld;
        if (wr_op == OP_LC_CLR) mask_q <= mask_q & ~mask_fld;
        if (wr_op == OP_LC_PIN)
          for (int s = 0; s < LS; s++)
            if (wr_src == LIDX_W'(s)) begin
              vld_q[s] <= vld_fld;
              pin_q[s] <= pin_fld;
            end
      end
    end

    assign live = loc_pend[c*LS +: LS] & mask_q & vld_q;

    always_comb begin
      req = '0;
      for (int p = 0; p < N_PINS; p++)
        for (int s = 0; s < LS; s++)
          if (live[s] && pin_q[s] == PW'(p)) req[p] = 1'b1;
    end

    assign loc_req[c*N_PINS +: N_PINS] = req;
    assign loc_mask[c*LS +: LS]        = mask_q;
  end
endmodule

// File: rtl/irq_pin_merge.sv
module irq_pin_merge #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sh_req,
  input  logic [W-1:0] loc_req,
  output logic [W-1:0] pins_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= '0;
    else        pins_q <= sh_req | loc_req;
  end
endmodule

// File: rtl/irq_core_pin_router.sv
module irq_core_pin_router #(
  parameter int unsigned N_SHARED = 16,
  parameter int unsigned N_CORES  = 4,
  parameter int unsigned N_PINS   = 6,
  localparam int unsigned CW = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int unsigned PW = (N_PINS > 1) ? $clog2(N_PINS) : 1,
  localparam int unsigned SW = (N_SHARED > 1) ? $clog2(N_SHARED) : 1,
  localparam int unsigned IW = (SW > 3) ? SW : 3,
  localparam int unsigned DW = irq_router_pkg::max3(N_CORES, irq_router_pkg::LOCAL_SRCS,
                                                    (PW > CW) ? PW : CW) + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_SHARED-1:0]        sh_pend,
  input  logic [N_CORES*7-1:0]       loc_pend,
  input  logic                       wr_en,
  input  logic [CW-1:0]              wr_core,
  input  logic                       wr_other,
  input  logic [2:0]                 wr_op,
  input  logic [IW-1:0]              wr_idx,
  input  logic [DW-1:0]              wr_data,
  output logic [N_CORES*N_PINS-1:0]  core_pins,
  output logic [CW-1:0]              cfg_cores_m1
);
  import irq_router_pkg::*;
  localparam int unsigned PINS_W = N_CORES * N_PINS;

  logic [CW-1:0]                   wr_target;
  logic [PINS_W-1:0]               sh_req;
  logic [PINS_W-1:0]               loc_req;
  logic [N_CORES*LOCAL_SRCS-1:0]   loc_mask;
  logic                            vld_fld;
  logic [PW-1:0]                   pin_fld;
  logic [IW-1:0]                   sh_idx;
  logic [DW-2:0]                   low_data;

  assign vld_fld  = wr_data[DW-1];
  assign low_data = wr_data[DW-2:0];
  assign pin_fld  = low_data[PW-1:0];
  assign sh_idx   = wr_idx;

  irq_other_sel #(.N_CORES(N_CORES), .CW(CW)) u_other (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op),
    .wr_core(wr_core), .wr_other(wr_other), .other_fld(low_data[CW-1:0]),
    .wr_target(wr_target)
  );

  irq_shared_map #(.N_SHARED(N_SHARED), .N_CORES(N_CORES), .N_PINS(N_PINS),
                   .IW(IW), .PW(PW)) u_shared (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op), .wr_idx(sh_idx),
    .vld_fld(vld_fld), .pin_fld(pin_fld), .core_fld(low_data[N_CORES-1:0]),
    .sh_pend(sh_pend), .sh_req(sh_req)
  );

  irq_local_bank #(.N_CORES(N_CORES), .N_PINS(N_PINS), .PW(PW), .CW(CW)) u_local (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op),
    .wr_src(wr_idx[LIDX_W-1:0]), .wr_target(wr_target),
    .vld_fld(vld_fld), .pin_fld(pin_fld), .mask_fld(low_data[LOCAL_SRCS-1:0]),
    .loc_pend(loc_pend), .loc_req(loc_req), .loc_mask(loc_mask)
  );

  irq_pin_merge #(.W(PINS_W)) u_merge (
    .clk(clk), .rst_n(rst_n), .sh_req(sh_req), .loc_req(loc_req), .pins_q(core_pins)
  );

  assign cfg_cores_m1 = CW'(N_CORES - 1);
endmodule

// File: rtl/irq_core_pin_router_chk.sv
module irq_core_pin_router_chk #(
  parameter int unsigned N_SHARED = 16,
  parameter int unsigned N_CORES  = 4,
  parameter int unsigned N_PINS   = 6
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [N_SHARED-1:0]         sh_pend,
  input logic [N_CORES*7-1:0]        loc_pend,
  input logic [N_CORES*N_PINS-1:0]   core_pins,
  input logic [N_CORES*N_PINS-1:0]   sh_req,
  input logic [N_CORES*N_PINS-1:0]   loc_req,
  input logic [N_CORES*7-1:0]        loc_mask
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> core_pins == '0);

  for (genvar v = 0; v < N_CORES; v++) begin : g_core
    p_merge_r9: assert property (@(posedge clk) disable iff (!rst_n)
      core_pins[v*N_PINS +: N_PINS] ==
        $past(sh_req[v*N_PINS +: N_PINS] | loc_req[v*N_PINS +: N_PINS]));

    p_shared_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_req[v*N_PINS +: N_PINS] != '0) |-> (sh_pend != '0));

    p_local_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_req[v*N_PINS +: N_PINS] != '0) |-> (loc_pend[v*7 +: 7] != '0));

    p_mask_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_mask[v*7 +: 7] == '0) |-> (loc_req[v*N_PINS +: N_PINS] == '0));
  end
endmodule

bind irq_core_pin_router irq_core_pin_router_chk #(
  .N_SHARED(N_SHARED), .N_CORES(N_CORES), .N_PINS(N_PINS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sh_pend(sh_pend), .loc_pend(loc_pend),
  .core_pins(core_pins), .sh_req(sh_req), .loc_req(loc_req), .loc_mask(loc_mask)
);

// File: tb/irq_core_pin_router_tb.sv
module irq_core_pin_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16, NC = 4, NP = 6, CW = 2, IW = 4, DW = 8;
  localparam int PINS = NC * NP;
  localparam int VB = 128;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NS-1:0]   sh_pend = '0;
  logic [NC*7-1:0] loc_pend = '0;
  logic            wr_en = 1'b0;
  logic [CW-1:0]   wr_core = '0;
  logic            wr_other = 1'b0;
  logic [2:0]      wr_op = '0;
  logic [IW-1:0]   wr_idx = '0;
  logic [DW-1:0]   wr_data = '0;
  logic [PINS-1:0] core_pins;
  logic [CW-1:0]   cfg_cores_m1;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  irq_core_pin_router u_dut (
    .clk(clk), .rst_n(rst_n), .sh_pend(sh_pend), .loc_pend(loc_pend),
    .wr_en(wr_en), .wr_core(wr_core), .wr_other(wr_other), .wr_op(wr_op),
    .wr_idx(wr_idx), .wr_data(wr_data), .core_pins(core_pins),
    .cfg_cores_m1(cfg_cores_m1)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [PINS-1:0] pb(input int c, input int p);
    return PINS'(1) << (c*NP + p);
  endfunction

  task automatic chk(input string req, input logic [PINS-1:0] got, input logic [PINS-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int core, input bit oth, input logic [2:0] op, input int idx,
                    input int data);
    wr_en = 1'b1; wr_core = CW'(core); wr_other = oth; wr_op = op;
    wr_idx = IW'(idx); wr_data = DW'(data);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_other = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 pins after reset", core_pins, '0);
    checks++;
    if (cfg_cores_m1 !== CW'(NC - 1)) begin
      failures++;
      $display("FAIL R2: got %0d expected %0d", cfg_cores_m1, NC - 1);
    end
    sh_pend = '1; loc_pend = '1;
    step(); step();
    chk("R1 unprogrammed with all pending", core_pins, '0);
    sh_pend = '0; loc_pend = '0;
    step();
  endtask

  task automatic t_shared();
    sh_pend[3] = 1'b1;
    wr(0, 0, 3'd0, 3, VB | 2);
    wr(0, 0, 3'd1, 3, 4'b0010);
    chk("R10 write not yet visible", core_pins, '0);
    step();
    chk("R3 shared 3 to core1 pin2", core_pins, pb(1, 2));
    sh_pend[3] = 1'b0;
    step();
    chk("R10 pending drop visible after one edge", core_pins, '0);
  endtask

  task automatic t_invalid();
    sh_pend[5] = 1'b1;
    wr(0, 0, 3'd1, 5, 4'b0001);
    wr(0, 0, 3'd0, 5, 3);
    step();
    chk("R4 valid clear drives nothing", core_pins, '0);
    wr(0, 0, 3'd0, 5, VB | 7);
    step();
    chk("R4 pin out of range drives nothing", core_pins, '0);
    wr(0, 0, 3'd0, 5, VB | 5);
    step();
    chk("R4 valid in range pin5", core_pins, pb(0, 5));
    wr(0, 0, 3'd0, 5, 0);
    step();
    chk("R4 valid cleared again", core_pins, '0);
    sh_pend[5] = 1'b0;
  endtask

  task automatic t_core_select();
    sh_pend[7] = 1'b1;
    wr(0, 0, 3'd0, 7, VB | 0);
    wr(0, 0, 3'd1, 7, 4'b1001);
    step();
    chk("R5 two cores selected", core_pins, pb(0, 0) | pb(3, 0));
    wr(0, 0, 3'd1, 7, 0);
    step();
    chk("R5 no core selected", core_pins, '0);
    sh_pend[7] = 1'b0;
  endtask

  task automatic t_local();
    loc_pend[2*7+2] = 1'b1;
    wr(2, 0, 3'd2, 2, VB | 4);
    step();
    chk("R7 masked timer source", core_pins, '0);
    wr(2, 0, 3'd3, 0, 7'b0000100);
    step();
    chk("R6 timer core2 pin4", core_pins, pb(2, 4));
    wr(2, 0, 3'd3, 0, 0);
    wr(2, 0, 3'd4, 0, 7'b0000001);
    step();
    chk("R7 zero bits leave mask", core_pins, pb(2, 4));
    loc_pend[2*7+6] = 1'b1;
    wr(2, 0, 3'd2, 6, VB | 1);
    wr(2, 0, 3'd3, 0, 7'b1000000);
    step();
    chk("R6 debug channel adds pin1", core_pins, pb(2, 4) | pb(2, 1));
    wr(2, 0, 3'd2, 7, VB | 0);
    step();
    chk("R6 source index 7 selects none", core_pins, pb(2, 4) | pb(2, 1));
    wr(2, 0, 3'd4, 0, 7'b1000100);
    step();
    chk("R7 mask clear", core_pins, '0);
    loc_pend = '0;
  endtask

  task automatic t_other();
    wr(0, 0, 3'd5, 0, 3);
    wr(0, 1, 3'd2, 0, VB | 3);
    wr(0, 1, 3'd3, 0, 7'b0000001);
    loc_pend[0] = 1'b1;
    loc_pend[3*7+0] = 1'b1;
    step(); step();
    chk("R8 redirected write hits core3 only", core_pins, pb(3, 3));
    wr(3, 0, 3'd6, 0, 8'hFF);
    wr(3, 0, 3'd7, 0, 8'hFF);
    step();
    chk("R8 codes 6 and 7 ignored", core_pins, pb(3, 3));
  endtask

  task automatic t_merge();
    sh_pend[9] = 1'b1;
    wr(0, 0, 3'd0, 9, VB | 3);
    wr(0, 0, 3'd1, 9, 4'b1000);
    step();
    chk("R9 shared and local on same pin", core_pins, pb(3, 3));
    loc_pend = '0;
    step();
    chk("R9 shared alone holds pin", core_pins, pb(3, 3));
    sh_pend[10] = 1'b1;
    wr(0, 0, 3'd0, 10, VB | 0);
    wr(0, 0, 3'd1, 10, 4'b1000);
    step();
    chk("R9 two pins on core3", core_pins, pb(3, 3) | pb(3, 0));
    sh_pend = '0;
    step();
    chk("R9 all dropped", core_pins, '0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL R10 watchdog: cycles=%0d expected below %0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_shared();
    t_invalid();
    t_core_select();
    t_local();
    t_other();
    t_merge();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule